// File: doc/BRIEF.md
# Cell Transmit Ingress Buffer

This block is the receiving end of a byte-wide, cell-oriented transmit link. A cell-layer device pushes fixed 53-byte cells into it over an 8-bit data bus, with a start-of-cell marker and an active-low enable. All of these are sampled on the rising edge of a byte clock that the far device supplies. The block tracks how many cell slots are free in its internal buffer. Its `cellAvail` output tells the sender that a whole cell can be accepted.

Inside, bytes are collected into the slot that is currently being filled, aligned to the start-of-cell marker. A cell that is cut short by a new start marker is dropped, and a sticky flag records the drop. A cell is handed to the internal read port only once all 53 of its bytes are stored. The read port is byte-serial. It shows the byte at the read position, marks the first byte of each cell, and moves forward one byte per accepted take.

Top module: `cell_tx_ingress`

## Requirements
- R1: `cellAvail` is high exactly when fewer than DEPTH_CELLS (default 4) complete cells are held. A cell still being read counts as held. `cellAvail` can only fall in the cycle after a cell completes, so it stays high through the transfer of the cell being collected.
- R2: A byte is captured only at a rising clock edge where `txEnbN` is 0. Cycles with `txEnbN` at 1 store nothing and do not advance the byte position, even when `txSoc` is 1.
- R3: A cell starts when `txEnbN` is 0 and `txSoc` is 1 while `cellAvail` is 1. That byte becomes byte 0 of the cell, stored with bit 7 kept as the most significant bit.
- R4: Bytes taken with `txEnbN` at 0 and `txSoc` at 0 while no cell is open are discarded and change no output.
- R5: A start marker that arrives before byte 53 of the open cell drops the partial cell. Collection restarts with the new byte as byte 0.
- R6: `errSticky` goes to 1 in the cycle after a partial cell is dropped and stays at 1 until reset.
- R7: `rdValid` rises in the cycle after the edge that stores the 53rd byte of a cell, and never earlier.
- R8: While `rdValid` is 1, `rdData` shows the unread byte at the read position and `rdFirst` is 1 on byte 0 of a cell. Each edge with `rdTake` at 1 advances one byte. Cells come out whole, in arrival order. `rdTake` has no effect while `rdValid` is 0.
- R9: A start marker that arrives while `cellAvail` is 0 opens no cell. The bytes that follow it are discarded and `errSticky` is left unchanged.
- R10: After reset, `cellAvail` is 1, `rdValid` is 0 and `errSticky` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock from the sending device, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| txEnbN | input | 1 | Active-low enable; data and start marker are valid when 0 |
| txSoc | input | 1 | High on the first byte of a cell |
| txData | input | DATA_W | Cell byte, bit 7 most significant |
| cellAvail | output | 1 | Room for one whole cell |
| rdValid | output | 1 | At least one complete cell is readable |
| rdFirst | output | 1 | Byte on `rdData` is byte 0 of a cell |
| rdData | output | DATA_W | Byte at the read position |
| rdTake | input | 1 | Consume the shown byte |
| errSticky | output | 1 | A partial cell was dropped since reset |

## Verification
The main function is driven with four kinds of input stream. The first is back-to-back cells with enable held low, which shows that alignment and byte order are correct. The second interleaves enable-high cycles that carry start-marker noise, which separates a design that gates on the enable from one that counts clock edges. The third cuts a cell short with a new start marker, which shows the difference between dropping the partial cell and merging it into the next. The fourth offers a cell while the buffer is full and also reads while a new cell is arriving, which tests whether space is tracked per whole cell or per byte. A behavioural queue model predicts every output on each cycle.

// File: rtl/cell_ingress_pkg.sv
package cell_ingress_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic wrStart;   // store byte at offset 0 of the current write slot
    logic wrNext;    // store byte at the running write offset
    logic wrCommit;  // final byte of the cell: move to the next write slot
    logic rdStep;    // move one byte forward inside the read slot
    logic rdCommit;  // last byte of the read slot consumed: move to next slot
  } ingressStrb_t;

endpackage

// File: rtl/cell_ingress_ctrl.sv
module cell_ingress_ctrl
  import cell_ingress_pkg::*;
#(
  parameter int unsigned CELL_BYTES  = 53,
  parameter int unsigned DEPTH_CELLS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         txEnbN,
  input  logic         txSoc,
  input  logic         rdTake,
  output ingressStrb_t strb,
  output logic         cellAvail,
  output logic         rdValid,
  output logic         rdFirst,
  output logic         errSticky
);

  localparam int unsigned POS_W   = $clog2(CELL_BYTES);
  localparam int unsigned STORE_W = $clog2(DEPTH_CELLS + 1);
  localparam logic [POS_W-1:0]   LAST_POS  = POS_W'(CELL_BYTES - 1);
  localparam logic [STORE_W-1:0] FULL_CNT  = STORE_W'(DEPTH_CELLS);

  logic               inCell;
  logic [POS_W-1:0]   wrPos;
  logic [POS_W-1:0]   rdPos;
  logic [STORE_W-1:0] heldCells;

  logic byteAccepted;
  logic startCell;
  logic contCell;
  logic lastByte;
  logic dropPartial;
  logic takeOk;
  logic takeLast;

  always_comb begin
    cellAvail    = heldCells < FULL_CNT;
    rdValid      = heldCells != '0;
    rdFirst      = rdValid && (rdPos == '0);
    byteAccepted = !txEnbN;
    startCell    = byteAccepted && txSoc && cellAvail;
    contCell     = byteAccepted && !txSoc && inCell;
    lastByte     = contCell && (wrPos == LAST_POS);
    dropPartial  = startCell && inCell;
    takeOk       = rdTake && rdValid;
    takeLast     = takeOk && (rdPos == LAST_POS);

    strb          = '0;
    strb.wrStart  = startCell;
    strb.wrNext   = contCell;
    strb.wrCommit = lastByte;
    strb.rdStep   = takeOk && !takeLast;
    strb.rdCommit = takeLast;
  end

  // Write-side state: open cell and byte position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inCell <= 1'b0;
      wrPos  <= '0;
    end else if (startCell) begin
      inCell <= 1'b1;
      wrPos  <= POS_W'(1);
    end else if (lastByte) begin
      inCell <= 1'b0;
      wrPos  <= '0;
    end else if (contCell) begin
      wrPos  <= wrPos + POS_W'(1);
    end
  end

  // Read-side position inside the oldest cell
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPos <= '0;
    end else if (takeLast) begin
      rdPos <= '0;
    end else if (takeOk) begin
      rdPos <= rdPos + POS_W'(1);
    end
  end

  // Occupied slot count: completed cells not yet fully read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldCells <= '0;
    end else begin
      case ({lastByte, takeLast})
        2'b10:   heldCells <= heldCells + STORE_W'(1);
        2'b01:   heldCells <= heldCells - STORE_W'(1);
        default: heldCells <= heldCells;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errSticky <= 1'b0;
    end else if (dropPartial) begin
      errSticky <= 1'b1;
    end
  end

endmodule

// File: rtl/cell_ingress_dp.sv
module cell_ingress_dp
  import cell_ingress_pkg::*;
#(
  parameter int unsigned CELL_BYTES  = 53,
  parameter int unsigned DEPTH_CELLS = 4,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ingressStrb_t      strb,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned BUF_BYTES = CELL_BYTES * DEPTH_CELLS;
  localparam int unsigned ADDR_W    = $clog2(BUF_BYTES);
  localparam logic [ADDR_W-1:0] STRIDE    = ADDR_W'(CELL_BYTES);
  localparam logic [ADDR_W-1:0] LAST_BASE = ADDR_W'(BUF_BYTES - CELL_BYTES);

  logic [DATA_W-1:0] cellMem [BUF_BYTES];

  logic [ADDR_W-1:0] wrBase;
  logic [ADDR_W-1:0] wrOff;
  logic [ADDR_W-1:0] rdBase;
  logic [ADDR_W-1:0] rdOff;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  function automatic logic [ADDR_W-1:0] nextBase(input logic [ADDR_W-1:0] base);
    return (base == LAST_BASE) ? '0 : base + STRIDE;
  endfunction

  always_comb begin
    wrAddr = strb.wrStart ? wrBase : wrBase + wrOff;
    rdAddr = rdBase + rdOff;
    rdData = cellMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (strb.wrStart || strb.wrNext) begin
      cellMem[wrAddr] <= txData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrBase <= '0;
      wrOff  <= '0;
    end else if (strb.wrStart) begin
      wrOff  <= ADDR_W'(1);
    end else if (strb.wrCommit) begin
      wrBase <= nextBase(wrBase);
      wrOff  <= '0;
    end else if (strb.wrNext) begin
      wrOff  <= wrOff + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBase <= '0;
      rdOff  <= '0;
    end else if (strb.rdCommit) begin
      rdBase <= nextBase(rdBase);
      rdOff  <= '0;
    end else if (strb.rdStep) begin
      rdOff  <= rdOff + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/cell_tx_ingress.sv
module cell_tx_ingress
  import cell_ingress_pkg::*;
#(
  parameter int unsigned CELL_BYTES  = 53,
  parameter int unsigned DEPTH_CELLS = 4,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnbN,
  input  logic              txSoc,
  input  logic [DATA_W-1:0] txData,
  output logic              cellAvail,
  output logic              rdValid,
  output logic              rdFirst,
  output logic [DATA_W-1:0] rdData,
  input  logic              rdTake,
  output logic              errSticky
);

  ingressStrb_t strb;

  cell_ingress_ctrl #(
    .CELL_BYTES (CELL_BYTES),
    .DEPTH_CELLS(DEPTH_CELLS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txEnbN   (txEnbN),
    .txSoc    (txSoc),
    .rdTake   (rdTake),
    .strb     (strb),
    .cellAvail(cellAvail),
    .rdValid  (rdValid),
    .rdFirst  (rdFirst),
    .errSticky(errSticky)
  );

  cell_ingress_dp #(
    .CELL_BYTES (CELL_BYTES),
    .DEPTH_CELLS(DEPTH_CELLS),
    .DATA_W     (DATA_W)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .txData(txData),
    .rdData(rdData)
  );

endmodule

// File: rtl/cell_ingress_chk.sv
module cell_ingress_chk
  import cell_ingress_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         txEnbN,
  input logic         cellAvail,
  input logic         rdValid,
  input logic         errSticky,
  input ingressStrb_t strb
);

  // R1: a full buffer always has something to read
  p_full_readable_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cellAvail |-> rdValid);

  // R1: space indication only drops right after a cell completes
  p_avail_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cellAvail) |-> $past(strb.wrCommit));

  // R2: no store while the enable is inactive
  p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    txEnbN |-> !(strb.wrStart || strb.wrNext));

  // R6: drop flag never clears outside reset
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  // R7: readable only after a completed cell
  p_visible_after_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdValid) |-> $past(strb.wrCommit));

  // R8: read pointer stays put when nothing is readable
  p_no_empty_take_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> !(strb.rdStep || strb.rdCommit));

endmodule

bind cell_tx_ingress cell_ingress_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .txEnbN   (txEnbN),
  .cellAvail(cellAvail),
  .rdValid  (rdValid),
  .errSticky(errSticky),
  .strb     (strb)
);

// File: tb/test_cell_tx_ingress.sv
module test_cell_tx_ingress;

  localparam int CB    = 53;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnbN = 1'b1;
  logic       txSoc = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       rdTake = 1'b0;
  logic       cellAvail, rdValid, rdFirst, errSticky;
  logic [7:0] rdData;

  int    vectors = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  string phaseTag = "R10";

  always #2.5 clk = ~clk;

  cell_tx_ingress #(.CELL_BYTES(CB), .DEPTH_CELLS(DEPTH), .DATA_W(8)) i_cell_tx_ingress (
    .clk(clk), .rstN(rstN), .txEnbN(txEnbN), .txSoc(txSoc), .txData(txData),
    .cellAvail(cellAvail), .rdValid(rdValid), .rdFirst(rdFirst), .rdData(rdData),
    .rdTake(rdTake), .errSticky(errSticky)
  );

  // Behavioural reference model
  byte unsigned doneQ[$];
  byte unsigned part[$];
  bit mIn = 0;
  bit mErr = 0;
  int rdPos = 0;

  function automatic int heldM();
    return (doneQ.size() + rdPos) / CB;
  endfunction

  always @(posedge clk) begin
    int  held;
    bit  availPre;
    if (!rstN) begin
      doneQ.delete(); part.delete(); mIn = 0; mErr = 0; rdPos = 0;
    end else begin
      held = heldM();
      availPre = held < DEPTH;
      if (rdTake && doneQ.size() > 0) begin
        void'(doneQ.pop_front());
        rdPos = (rdPos + 1) % CB;
      end
      if (!txEnbN) begin
        if (txSoc && availPre) begin
          if (mIn) mErr = 1;
          part.delete();
          part.push_back(txData);
          mIn = 1;
        end else if (!txSoc && mIn) begin
          part.push_back(txData);
          if (part.size() == CB) begin
            foreach (part[k]) doneQ.push_back(part[k]);
            part.delete();
            mIn = 0;
          end
        end
      end
    end
  end

  task automatic chk(string req, string name, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) %s: actual %0h expected %0h", req, phaseTag, name, act, exp);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R1", "cellAvail", int'(cellAvail), int'(heldM() < DEPTH));
      chk("R7", "rdValid", int'(rdValid), int'(doneQ.size() > 0));
      chk("R6", "errSticky", int'(errSticky), int'(mErr));
      if (doneQ.size() > 0) begin
        chk("R8", "rdData", int'(rdData), int'(doneQ[0]));
        chk("R8", "rdFirst", int'(rdFirst), int'(rdPos == 0));
      end
    end
  end

  task automatic drive(bit enbN, bit soc, logic [7:0] d);
    @(negedge clk);
    txEnbN = enbN; txSoc = soc; txData = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 8'h00);
  endtask

  task automatic sendBytes(logic [7:0] base, int count, int gapEvery);
    for (int i = 0; i < count; i++) begin
      if (gapEvery > 0 && (i % gapEvery) == 1) drive(1'b1, 1'b1, 8'hFF);
      drive(1'b0, i == 0, base + 8'(i));
    end
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdTake = 1'b1;
    end
    @(negedge clk);
    rdTake = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    phaseTag = "R10";
    chk("R10", "cellAvail reset", int'(cellAvail), 1);
    chk("R10", "rdValid reset", int'(rdValid), 0);
    chk("R10", "errSticky reset", int'(errSticky), 0);
    rstN = 1'b1;
    idle(2);

    phaseTag = "R4";
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 8'h33);
    idle(2);
    chk("R4", "rdValid after stray bytes", int'(rdValid), 0);
    chk("R4", "errSticky after stray bytes", int'(errSticky), 0);

    phaseTag = "R3";
    sendBytes(8'h80, CB - 1, 0);
    idle(1);
    chk("R7", "rdValid before last byte", int'(rdValid), 0);
    drive(1'b0, 1'b0, 8'h80 + 8'(CB - 1));
    idle(1);
    chk("R7", "rdValid after last byte", int'(rdValid), 1);
    chk("R3", "first byte msb kept", int'(rdData), 8'h80);
    chk("R3", "rdFirst on byte 0", int'(rdFirst), 1);

    phaseTag = "R2";
    sendBytes(8'h10, CB, 7);
    idle(2);

    phaseTag = "R5";
    sendBytes(8'h40, 20, 0);
    sendBytes(8'hC0, CB, 0);
    idle(2);
    chk("R6", "errSticky after drop", int'(errSticky), 1);

    phaseTag = "R1";
    sendBytes(8'h20, CB, 0);
    idle(2);
    chk("R1", "cellAvail when full", int'(cellAvail), 0);

    phaseTag = "R9";
    sendBytes(8'h60, CB, 0);
    idle(2);
    chk("R9", "cellAvail still full", int'(cellAvail), 0);

    phaseTag = "R8";
    fork
      drain(CB * 5 + 10);
      begin
        idle(60);
        sendBytes(8'h30, CB, 3);
        idle(2);
      end
    join
    idle(3);
    chk("R8", "rdValid after full drain", int'(rdValid), 0);
    chk("R1", "cellAvail after drain", int'(cellAvail), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule